// File: doc/BRIEF.md
# Sixteen-Entry Tag Lookup Table with Replacement Tracking

This block is a small associative table that several threads share in order to find work items already in flight. Each of its sixteen slots holds a 32-bit tag, a valid flag and four state bits. The state bits belong to software: they never influence matching or ordering. They are simply returned with the result. A lookup presents a key, and every valid tag is compared with it at the same time. One cycle later the block returns a single 9-bit result word.

On a hit, the word carries the slot number and that slot's state bits. On a miss, it carries the number of the slot that was used least recently, so software can overwrite that slot without searching for a victim. A write port loads a tag and state bits into a named slot and marks the slot valid. A clear input empties the whole table. Both a lookup hit and a write count as a use of the slot and make it the most recent.

Top module: `cam_lru_table`

## Requirements
- R1: After reset, and in the cycle after a clear, every slot is invalid and the use order is reset so that slot i is the i-th oldest. Any lookup then misses and reports slot 0, even for the key 0 that matches the reset tag contents.
- R2: `res_valid` is high exactly in the cycle after a cycle with `lk_valid` high and `clear` low. `res_word` changes only in those cycles.
- R3: `res_word` is laid out as bit 8 = hit, bits 7:4 = state bits, bits 3:0 = slot number.
- R4: A lookup whose key equals the tag of a valid slot returns hit = 1 with that slot's number and the state bits stored in it. Every slot is compared.
- R5: When several valid slots hold the key, the lowest slot number is returned.
- R6: A lookup that misses returns hit = 0, state bits 0, and the number of the least recently used slot.
- R7: A lookup hit makes the matched slot the most recently used. The relative order of the other slots is kept.
- R8: A write (`wr_en` high, `clear` low) stores `wr_tag` and `wr_state` into slot `wr_slot`, marks the slot valid and makes it the most recently used.
- R9: The state bits have no effect on matching or on use order. Rewriting a slot with new state bits and the same tag still hits and returns the new bits.
- R10: `clear` has priority. In a cycle with `clear` high, a write is discarded and a lookup produces no result (`res_valid` stays low in the next cycle).
- R11: A lookup and a write in the same cycle: the lookup sees the table contents from before the write. The hit (if any) is applied to the use order first, and the written slot then becomes the most recently used.
- R12: A miss leaves the use order unchanged, so two misses in a row with no write in between report the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_key | input | 32 | Lookup key |
| wr_en | input | 1 | Slot write request |
| wr_slot | input | 4 | Slot to write |
| wr_tag | input | 32 | Tag to store |
| wr_state | input | 4 | Software state bits to store |
| clear | input | 1 | Invalidate all slots and reset the use order |
| res_valid | output | 1 | Result word is valid this cycle |
| res_word | output | 9 | {hit, state[3:0], slot[3:0]} |

## Verification
The bench keeps its own model of the table and of the oldest-to-newest order, and it compares every result word with that model. It probes the key 0 right after reset: a design that matched reset tags without checking the valid flag would report a hit there. It plants a duplicate tag in a higher slot: a design with a wrong priority encoder would return the newer slot. It issues back-to-back misses: a design that aged entries on a miss would move the victim. It also drives a write together with a lookup of the tag being written, and a clear together with both. A design that forwarded the write, or let either operation through during a clear, would return a hit or a stray result.

// File: rtl/cam_lru_table.sv
module cam_lru_table #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 32,
  parameter int STATE_W = 4,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int RES_W  = 1 + STATE_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [KEY_W-1:0]   lk_key,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_slot,
  input  logic [KEY_W-1:0]   wr_tag,
  input  logic [STATE_W-1:0] wr_state,
  input  logic               clear,
  output logic               res_valid,
  output logic [RES_W-1:0]   res_word
);

  localparam logic [IDX_W-1:0] NEWEST = IDX_W'(ENTRIES - 1);

  logic [KEY_W-1:0]   tag_q   [ENTRIES];
  logic [STATE_W-1:0] state_q [ENTRIES];
  logic [IDX_W-1:0]   age_q   [ENTRIES];
  logic [IDX_W-1:0]   age_mid [ENTRIES];
  logic [IDX_W-1:0]   age_nxt [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   old_idx;
  logic               hit;
  logic               do_hit;
  logic               do_wr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == lk_key);
  end

  assign hit    = |match;
  assign do_hit = lk_valid && !clear && hit;
  assign do_wr  = wr_en && !clear;

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) hit_idx = IDX_W'(i);
  end

  always_comb begin
    old_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (age_q[i] == '0) old_idx = IDX_W'(i);
  end

  always_comb begin
    age_mid = age_q;
    if (do_hit) begin
      for (int i = 0; i < ENTRIES; i++)
        if (age_q[i] > age_q[hit_idx]) age_mid[i] = age_q[i] - 1'b1;
      age_mid[hit_idx] = NEWEST;
    end
    age_nxt = age_mid;
    if (do_wr) begin
      for (int i = 0; i < ENTRIES; i++)
        if (age_mid[i] > age_mid[wr_slot]) age_nxt[i] = age_mid[i] - 1'b1;
      age_nxt[wr_slot] = NEWEST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= '0;
      res_valid <= 1'b0;
      res_word  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]   <= '0;
        state_q[i] <= '0;
        age_q[i]   <= IDX_W'(i);
      end
    end else if (clear) begin
      valid_q   <= '0;
      res_valid <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else begin
      age_q     <= age_nxt;
      res_valid <= lk_valid;
      if (lk_valid)
        res_word <= hit ? {1'b1, state_q[hit_idx], hit_idx}
                        : {1'b0, {STATE_W{1'b0}}, old_idx};
      if (do_wr) begin
        tag_q[wr_slot]   <= wr_tag;
        state_q[wr_slot] <= wr_state;
        valid_q[wr_slot] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cam_lru_table_chk.sv
module cam_lru_table_chk #(
  parameter int ENTRIES = 16,
  parameter int STATE_W = 4,
  parameter int IDX_W   = 4,
  parameter int RES_W   = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             wr_en,
  input logic             clear,
  input logic             res_valid,
  input logic [RES_W-1:0] res_word,
  input logic [IDX_W-1:0] age_q [ENTRIES]
);

  logic perm_ok;
  always_comb begin
    perm_ok = 1'b1;
    for (int v = 0; v < ENTRIES; v++) begin
      int cnt;
      cnt = 0;
      for (int i = 0; i < ENTRIES; i++)
        if (age_q[i] == IDX_W'(v)) cnt++;
      if (cnt != 1) perm_ok = 1'b0;
    end
  end

  wire              r_hit = res_word[RES_W-1];
  wire [IDX_W-1:0]  r_idx = res_word[IDX_W-1:0];

  assert_result_follows_lookup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !clear) |=> res_valid);

  assert_idle_no_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);

  assert_clear_blocks_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !res_valid);

  assert_clear_resets_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (age_q[0] == '0));

  assert_miss_state_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !r_hit) |-> (res_word[IDX_W +: STATE_W] == '0));

  assert_miss_names_oldest_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !r_hit && $past(!wr_en)) |-> (age_q[r_idx] == '0));

  assert_hit_becomes_newest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && r_hit && $past(!wr_en)) |-> (age_q[r_idx] == IDX_W'(ENTRIES - 1)));

  assert_order_is_permutation_R8: assert property (@(posedge clk) disable iff (!rst_n)
    perm_ok);

endmodule

bind cam_lru_table cam_lru_table_chk #(
  .ENTRIES(ENTRIES), .STATE_W(STATE_W), .IDX_W(IDX_W), .RES_W(RES_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .wr_en(wr_en), .clear(clear),
  .res_valid(res_valid), .res_word(res_word), .age_q(age_q)
);

// File: tb/cam_lru_table_tb_top.sv
module cam_lru_table_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_key = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_slot = '0;
  logic [31:0] wr_tag = '0;
  logic [3:0]  wr_state = '0;
  logic        clear = 1'b0;
  logic        res_valid;
  logic [8:0]  res_word;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_tag   [16];
  logic [3:0]  m_state [16];
  bit          m_valid [16];
  int          m_order [16];

  always #2 clk = ~clk;

  cam_lru_table dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void m_reset();
    for (int i = 0; i < 16; i++) begin
      m_valid[i] = 0;
      m_order[i] = i;
    end
  endfunction

  function automatic void m_touch(input int k);
    int p = 0;
    for (int i = 0; i < 16; i++) if (m_order[i] == k) p = i;
    for (int i = p; i < 15; i++) m_order[i] = m_order[i+1];
    m_order[15] = k;
  endfunction

  function automatic logic [8:0] m_result(input logic [31:0] key);
    for (int i = 0; i < 16; i++)
      if (m_valid[i] && m_tag[i] == key) return {1'b1, m_state[i], 4'(i)};
    return {1'b0, 4'h0, 4'(m_order[0])};
  endfunction

  function automatic void m_write(input int k, input logic [31:0] t, input logic [3:0] s);
    m_tag[k] = t; m_state[k] = s; m_valid[k] = 1; m_touch(k);
  endfunction

  task automatic do_write(input int k, input logic [31:0] t, input logic [3:0] s);
    @(negedge clk);
    wr_en = 1; wr_slot = 4'(k); wr_tag = t; wr_state = s;
    @(posedge clk);
    m_write(k, t, s);
    @(negedge clk);
    wr_en = 0;
    chk("R8 write yields no result", 32'(res_valid), 32'd0);
  endtask

  task automatic do_lookup(input logic [31:0] key, input string req);
    logic [8:0] e;
    @(negedge clk);
    lk_valid = 1; lk_key = key;
    e = m_result(key);
    @(posedge clk);
    if (e[8]) m_touch(int'(e[3:0]));
    @(negedge clk);
    lk_valid = 0;
    chk({req, " res_valid"}, 32'(res_valid), 32'd1);
    chk({req, " res_word"}, 32'(res_word), 32'(e));
  endtask

  task automatic t_reset();
    chk("R1 reset res_valid", 32'(res_valid), 32'd0);
    chk("R1 reset res_word", 32'(res_word), 32'd0);
    do_lookup(32'h0, "R1 key zero misses to slot 0");
    chk("R1 reset victim is slot 0", 32'(res_word), 32'h000);
    @(negedge clk);
    chk("R2 no result without lookup", 32'(res_valid), 32'd0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 16; i++) do_write(i, 32'h5A00_0000 + 32'(i * 32'h1013), 4'(i) ^ 4'hA);
    for (int i = 15; i >= 0; i--) do_lookup(32'h5A00_0000 + 32'(i * 32'h1013), "R4 R3 hit slot");
  endtask

  task automatic t_order();
    do_lookup(32'hDEAD_BEEF, "R6 miss names oldest");
    chk("R6 oldest is slot 15 after reverse hits", 32'(res_word[3:0]), 32'd15);
    do_lookup(32'hDEAD_BEEF, "R12 repeat miss same victim");
    do_lookup(32'h5A00_0000 + 32'(15 * 32'h1013), "R7 hit on oldest");
    do_lookup(32'h5A00_0000 + 32'(3 * 32'h1013), "R7 hit on slot 3");
    do_lookup(32'h0BAD_F00D, "R7 victim after reorder");
    chk("R7 victim is slot 14", 32'(res_word[3:0]), 32'd14);
  endtask

  task automatic t_dup();
    do_write(9, 32'h5A00_0000 + 32'(2 * 32'h1013), 4'h3);
    do_lookup(32'h5A00_0000 + 32'(2 * 32'h1013), "R5 lowest slot wins");
    chk("R5 slot number", 32'(res_word[3:0]), 32'd2);
  endtask

  task automatic t_state();
    do_write(4, 32'h5A00_0000 + 32'(4 * 32'h1013), 4'hF);
    do_lookup(32'h5A00_0000 + 32'(4 * 32'h1013), "R9 new state returned");
    chk("R9 state field", 32'(res_word[7:4]), 32'hF);
    do_write(4, 32'h5A00_0000 + 32'(4 * 32'h1013), 4'h0);
    do_lookup(32'h5A00_0000 + 32'(4 * 32'h1013), "R9 zero state still hits");
    chk("R9 hit flag", 32'(res_word[8]), 32'd1);
  endtask

  task automatic t_same_cycle();
    logic [8:0] e;
    @(negedge clk);
    lk_valid = 1; lk_key = 32'h7777_0001;
    wr_en = 1; wr_slot = 4'd6; wr_tag = 32'h7777_0001; wr_state = 4'h5;
    e = m_result(32'h7777_0001);
    @(posedge clk);
    m_write(6, 32'h7777_0001, 4'h5);
    @(negedge clk);
    lk_valid = 0; wr_en = 0;
    chk("R11 lookup sees old contents", 32'(res_word), 32'(e));
    @(negedge clk);
    lk_valid = 1; lk_key = 32'h5A00_0000 + 32'(8 * 32'h1013);
    wr_en = 1; wr_slot = 4'd1; wr_tag = 32'h7777_0002; wr_state = 4'h1;
    e = m_result(lk_key);
    @(posedge clk);
    if (e[8]) m_touch(int'(e[3:0]));
    m_write(1, 32'h7777_0002, 4'h1);
    @(negedge clk);
    lk_valid = 0; wr_en = 0;
    chk("R11 hit with concurrent write", 32'(res_word), 32'(e));
    do_lookup(32'h7777_0001, "R11 written tag now hits");
    do_lookup(32'hFFFF_0000, "R11 order after hit then write");
  endtask

  task automatic t_clear();
    @(negedge clk);
    clear = 1; lk_valid = 1; lk_key = 32'h7777_0001;
    wr_en = 1; wr_slot = 4'd5; wr_tag = 32'h9999_0000; wr_state = 4'h7;
    @(posedge clk);
    m_reset();
    @(negedge clk);
    clear = 0; lk_valid = 0; wr_en = 0;
    chk("R10 no result during clear", 32'(res_valid), 32'd0);
    do_lookup(32'h9999_0000, "R10 write during clear dropped");
    chk("R10 dropped write misses to slot 0", 32'(res_word), 32'h000);
    do_lookup(32'h7777_0001, "R1 old tag misses after clear");
    do_write(0, 32'h1111_2222, 4'h9);
    do_lookup(32'h0, "R8 write moves slot 0 to newest");
    chk("R8 victim is slot 1", 32'(res_word[3:0]), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fill();
    t_order();
    t_dup();
    t_state();
    t_same_cycle();
    t_clear();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule